// File: doc/BRIEF.md
# Flash Read Configuration Command Interface

This block is the command-decode front end of a NOR-style flash device. It watches a simple asynchronous-style bus (chip enable, write enable, address-valid and output-enable strobes, all active low), sampled by the device clock. It recognises a two-write sequence that loads a 16-bit read configuration word. That word travels on the address lines, not on the data lines, in both writes. The stored word drives the burst read logic through `cfg_word`.

Software reads the stored word back by entering an identifier mode and reading offset 05h. Identifier mode lasts until a read-array command is written. Outside identifier mode, reads return the array data presented on `array_rdata`. The block only decodes commands. The array, program/erase sequencing and the burst datapath live elsewhere.

Top module: `fcr_cmd_if`

## Requirements
- R1: After reset `cfg_word` is 16'hBFC0. In that value bit 15 (read mode) is 1, selecting asynchronous reads, bits 13:11 (latency code) are 111, bits 10, 9, 8, 7 and 6 are 1, and all other bits are 0.
- R2: Writing command byte 60h and then command byte 03h, with the same value on `addr[15:0]` in both writes, loads that address value into `cfg_word`. The bus is then in array mode. The sequence works whether it starts from array mode or from identifier mode.
- R3: A write cycle is the interval in which `ce_n` and `we_n` are both low. Its address is captured at the first rising edge of `adv_n`, `ce_n` or `we_n` within that cycle. Later address changes in the same cycle are ignored. The command byte on `wdata` is sampled when `ce_n` or `we_n` first rises, which ends the write.
- R4: A second write whose byte is not 03h aborts the sequence. `cfg_word` is unchanged and the mode becomes array mode. A 03h write outside the sequence is ignored.
- R5: If the confirm address differs from the setup address, `cfg_word` is unchanged and the mode becomes array mode.
- R6: Command byte 90h enters identifier mode. A read whose low 8 address bits are 05h returns `cfg_word`. Reads at any other low-byte offset return zero. The mode persists across reads.
- R7: Command byte FFh selects array mode. In array mode a read returns `array_rdata`.
- R8: `rd_data` is registered. It shows the read result in the clock cycle after a clock edge that samples `ce_n` and `oe_n` both low, and is zero after an edge that samples either of them high.
- R9: Reset, from any mode, selects array mode and restores the R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 16 | Address lines; carry the configuration word in command writes |
| wdata | input | 8 | Command byte lines |
| array_rdata | input | 16 | Data from the array, returned in array mode |
| rd_data | output | 16 | Registered read result |
| cfg_word | output | 16 | Stored read configuration word |

## Verification
Address capture and write completion can land on the same clock edge. This happens when `adv_n` rises together with `we_n`. In that case the address must come from the live bus, not from an earlier capture. The bench provokes this on purpose, next to the cases where `adv_n` rises early and the address is then scrambled, and where `ce_n` ends the write. Each case is judged by the value that appears on `cfg_word` and by an identifier-mode readback of offset 05h.

// File: rtl/fcr_pkg.sv
// Package: shared constants and types for the read configuration command
// interface. Assumes an 8-bit command byte and a 16-bit configuration word.
package fcr_pkg;
    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'h03;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    localparam logic [15:0] CFG_RESET  = 16'hBFC0;
    localparam logic [7:0]  ID_CFG_OFS = 8'h05;

    // strobe vector positions
    localparam int NSTB    = 3;
    localparam int STB_CE  = 0;
    localparam int STB_WE  = 1;
    localparam int STB_ADV = 2;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_SETUP = 2'd1,
        MODE_IDENT = 2'd2
    } mode_e;
endpackage

// File: rtl/fcr_strobe_edge.sv
// Module: turns sampled bus strobes into one write event per bus write.
// Captures the address at the first rising strobe (address-valid, chip
// enable or write enable) inside a write. Emits a one-cycle event with the
// captured address and the command byte when chip enable or write enable
// first rises. Assumes the strobes are already synchronous to clk.
module fcr_strobe_edge
    import fcr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTB-1:0]   stb_n,
    input  logic [WORD_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_addr,
    output logic [CMD_W-1:0]  wr_cmd
);
    logic [NSTB-1:0]   stb_q;
    logic [NSTB-1:0]   stb_rise;
    logic              taken;
    logic [WORD_W-1:0] addr_hold;
    logic              in_write;
    logic              cap_now;
    logic              commit;
    logic [WORD_W-1:0] commit_addr;

    // one rising-edge detector per strobe
    for (genvar g = 0; g < NSTB; g++) begin : g_rise
        assign stb_rise[g] = stb_n[g] & ~stb_q[g];
    end

    // decide capture and completion for the current edge
    always_comb begin
        in_write    = ~stb_q[STB_CE] & ~stb_q[STB_WE];
        cap_now     = in_write & ~taken & (|stb_rise);
        commit      = in_write & (stb_n[STB_CE] | stb_n[STB_WE]);
        commit_addr = cap_now ? addr : addr_hold;
    end

    // strobe history, address hold and write event register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q     <= '1;
            taken     <= 1'b0;
            addr_hold <= '0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_cmd    <= '0;
        end else begin
            stb_q    <= stb_n;
            wr_valid <= commit;
            if (commit) begin
                wr_addr <= commit_addr;
                wr_cmd  <= cmd;
                taken   <= 1'b0;
            end else if (cap_now) begin
                addr_hold <= addr;
                taken     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcr_cmd_fsm.sv
// Module: command state machine. Tracks array, setup and identifier modes.
// Issues a load pulse when a confirm write matches the setup address.
// Assumes at most one write event per cycle from the strobe stage.
module fcr_cmd_fsm
    import fcr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_addr,
    input  logic [CMD_W-1:0]  wr_cmd,
    output mode_e             mode,
    output logic              load,
    output logic [WORD_W-1:0] load_val
);
    mode_e             mode_q, mode_d;
    logic [WORD_W-1:0] setup_q, setup_d;

    // next mode, setup address and load decision
    always_comb begin
        mode_d  = mode_q;
        setup_d = setup_q;
        load    = 1'b0;
        if (wr_valid) begin
            if (mode_q == MODE_SETUP) begin
                mode_d = MODE_ARRAY;
                load   = (wr_cmd == CMD_CONFIRM) && (wr_addr == setup_q);
            end else begin
                case (wr_cmd)
                    CMD_SETUP: begin
                        mode_d  = MODE_SETUP;
                        setup_d = wr_addr;
                    end
                    CMD_IDENT: mode_d = MODE_IDENT;
                    CMD_ARRAY: mode_d = MODE_ARRAY;
                    default:   mode_d = mode_q;
                endcase
            end
        end
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_ARRAY;
            setup_q <= '0;
        end else begin
            mode_q  <= mode_d;
            setup_q <= setup_d;
        end
    end

    assign mode     = mode_q;
    assign load_val = wr_addr;
endmodule

// File: rtl/fcr_cfg_store.sv
// Module: holds the configuration word and forms the registered read data.
// Returns the word at the identifier offset in identifier mode, zero at other
// identifier offsets, and array data otherwise. Assumes the read offset is
// the low byte of the address.
module fcr_cfg_store
    import fcr_pkg::*;
#(
    parameter int              WORD_W  = 16,
    parameter int              OFS_W   = 8,
    parameter logic [OFS_W-1:0] CFG_OFS = ID_CFG_OFS,
    parameter logic [WORD_W-1:0] RST_VAL = CFG_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  mode_e             mode,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  rd_ofs,
    input  logic [WORD_W-1:0] array_rdata,
    output logic [WORD_W-1:0] cfg_word,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] rd_next;

    // configuration word register
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= RST_VAL;
        else if (load) cfg_q <= load_val;
    end

    // read source selection
    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            if (mode == MODE_IDENT) rd_next = (rd_ofs == CFG_OFS) ? cfg_q : '0;
            else                    rd_next = array_rdata;
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    assign cfg_word = cfg_q;
endmodule

// File: rtl/fcr_cmd_if.sv
// Module: top of the read configuration command interface. Ties the strobe
// stage, command state machine and configuration store together. Assumes all
// bus inputs are synchronous to clk.
module fcr_cmd_if
    import fcr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CMD_W  = 8,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              adv_n,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] addr,
    input  logic [CMD_W-1:0]  wdata,
    input  logic [WORD_W-1:0] array_rdata,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] cfg_word
);
    logic [NSTB-1:0]   stb_n;
    logic              wr_valid;
    logic [WORD_W-1:0] wr_addr;
    logic [CMD_W-1:0]  wr_cmd;
    mode_e             mode;
    logic              load;
    logic [WORD_W-1:0] load_val;
    logic              rd_en;

    // gather strobes and read enable
    always_comb begin
        stb_n          = '1;
        stb_n[STB_CE]  = ce_n;
        stb_n[STB_WE]  = we_n;
        stb_n[STB_ADV] = adv_n;
        rd_en          = ~ce_n & ~oe_n;
    end

    fcr_strobe_edge #(.WORD_W(WORD_W), .CMD_W(CMD_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_n    (stb_n),
        .addr     (addr),
        .cmd      (wdata),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_cmd   (wr_cmd)
    );

    fcr_cmd_fsm #(.WORD_W(WORD_W), .CMD_W(CMD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_cmd   (wr_cmd),
        .mode     (mode),
        .load     (load),
        .load_val (load_val)
    );

    fcr_cfg_store #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_val    (load_val),
        .mode        (mode),
        .rd_en       (rd_en),
        .rd_ofs      (addr[OFS_W-1:0]),
        .array_rdata (array_rdata),
        .cfg_word    (cfg_word),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/fcr_cmd_if_chk.sv
// Module: property checker for fcr_cmd_if, attached by bind below.
module fcr_cmd_if_chk
    import fcr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic [15:0] addr,
    input logic [15:0] rd_data,
    input logic [15:0] cfg_word,
    input logic        wr_valid,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_cmd,
    input mode_e       mode
);
    assert_reset_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_word == CFG_RESET);

    assert_load_needs_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word != $past(cfg_word)) |-> ($past(wr_valid) && $past(wr_cmd) == CMD_CONFIRM));

    assert_load_value_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word != $past(cfg_word)) |-> cfg_word == $past(wr_addr));

    assert_seq_ends_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && mode == MODE_SETUP) |=> mode == MODE_ARRAY);

    assert_array_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && mode != MODE_SETUP && wr_cmd == CMD_ARRAY) |=> mode == MODE_ARRAY);

    assert_ident_other_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode == MODE_IDENT && !ce_n && !oe_n && addr[7:0] != ID_CFG_OFS) |-> rd_data == '0);

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n || oe_n) |-> rd_data == '0);
endmodule

bind fcr_cmd_if fcr_cmd_if_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .rd_data  (rd_data),
    .cfg_word (cfg_word),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_cmd   (wr_cmd),
    .mode     (mode)
);

// File: tb/fcr_cmd_if_tb_top.sv
// Bench: scoreboard for fcr_cmd_if. Read tasks queue expected words; a monitor
// pops and compares them one cycle after each sampled read.
module fcr_cmd_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n, we_n, adv_n, oe_n;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [15:0] array_rdata;
    logic [15:0] rd_data;
    logic [15:0] cfg_word;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    logic  rd_pend = 1'b0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    assign array_rdata = addr ^ 16'hA5A5;

    fcr_cmd_if dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .we_n        (we_n),
        .adv_n       (adv_n),
        .oe_n        (oe_n),
        .addr        (addr),
        .wdata       (wdata),
        .array_rdata (array_rdata),
        .rd_data     (rd_data),
        .cfg_word    (cfg_word)
    );

    // remember which edges sampled a read
    always @(posedge clk) rd_pend <= !ce_n && !oe_n;

    // monitor: compare read results against the queue
    always @(negedge clk) begin
        item_t it;
        if (rd_pend) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected read result %h, expected none", rd_data);
            end else begin
                it = q.pop_front();
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // style 0: WE ends; 1: ADV rises first then address scrambled;
    // 2: CE ends; 3: ADV and WE rise together
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input int style);
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        case (style)
            1: begin
                adv_n = 1'b1;
                @(negedge clk);
                addr = ~a;
                @(negedge clk);
                we_n = 1'b1;
            end
            2: begin
                ce_n = 1'b1;
                @(negedge clk);
                we_n = 1'b1;
            end
            3: begin
                adv_n = 1'b1;
                we_n  = 1'b1;
            end
            default: we_n = 1'b1;
        endcase
        @(negedge clk);
        ce_n = 1'b1; adv_n = 1'b1; we_n = 1'b1; addr = '0; wdata = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        q.push_back('{exp, tag});
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; addr = '0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [15:0] v, input int style);
        bus_write(v, 8'h60, style);
        bus_write(v, 8'h03, style);
    endtask

    task automatic finish_run();
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R8: %0d reads never returned, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            finish_run();
        end
    end

    // stimulus
    initial begin
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; adv_n = 1'b1; oe_n = 1'b1;
        addr = '0; wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check_eq("R1 reset value", cfg_word, 16'hBFC0);
        check_eq("R8 idle output", rd_data, 16'h0000);
        bus_read(16'h0005, 16'h0005 ^ 16'hA5A5, "R9 array mode after reset");

        // identifier mode
        bus_write(16'h0000, 8'h90, 0);
        bus_read(16'h0005, 16'hBFC0, "R1 readback of reset value");
        bus_read(16'h0006, 16'h0000, "R6 other offset zero");
        bus_read(16'h0105, 16'hBFC0, "R6 low byte offset");
        bus_read(16'h0005, 16'hBFC0, "R6 mode persists");
        bus_write(16'h0000, 8'hFF, 0);
        bus_read(16'h0005, 16'h0005 ^ 16'hA5A5, "R7 back to array");

        // load variants
        set_cfg(16'h1234, 0);
        check_eq("R2 load via WE end", cfg_word, 16'h1234);
        bus_read(16'h0005, 16'h0005 ^ 16'hA5A5, "R2 array after sequence");
        set_cfg(16'h4321, 1);
        check_eq("R3 ADV first capture", cfg_word, 16'h4321);
        set_cfg(16'h0F0F, 2);
        check_eq("R3 CE end capture", cfg_word, 16'h0F0F);
        set_cfg(16'h8001, 3);
        check_eq("R3 ADV with WE same edge", cfg_word, 16'h8001);

        // abort by wrong confirm byte
        bus_write(16'h00A5, 8'h60, 0);
        bus_write(16'h00A5, 8'h70, 0);
        check_eq("R4 bad confirm keeps value", cfg_word, 16'h8001);
        bus_read(16'h0005, 16'h0005 ^ 16'hA5A5, "R4 array after abort");
        bus_write(16'h1111, 8'h03, 0);
        check_eq("R4 lone confirm ignored", cfg_word, 16'h8001);

        // abort by address mismatch
        bus_write(16'h2222, 8'h60, 0);
        bus_write(16'h3333, 8'h03, 0);
        check_eq("R5 mismatch keeps value", cfg_word, 16'h8001);
        bus_read(16'h0005, 16'h0005 ^ 16'hA5A5, "R5 array after mismatch");

        // sequence started from identifier mode
        bus_write(16'h0000, 8'h90, 0);
        set_cfg(16'h00C3, 0);
        check_eq("R2 load from ident", cfg_word, 16'h00C3);
        bus_read(16'h0005, 16'h0005 ^ 16'hA5A5, "R2 exits ident");
        bus_write(16'h0000, 8'h90, 0);
        bus_read(16'h0005, 16'h00C3, "R6 readback of loaded value");

        // output enable alone does not read
        @(negedge clk);
        oe_n = 1'b0; addr = 16'h0005;
        @(negedge clk);
        check_eq("R8 zero without chip enable", rd_data, 16'h0000);
        oe_n = 1'b1; addr = '0;

        // reset from identifier mode
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R9 reset restores value", cfg_word, 16'hBFC0);
        bus_read(16'h0005, 16'h0005 ^ 16'hA5A5, "R9 reset selects array");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule